// File: doc/BRIEF.md
# Rotate-and-Mask Execution Unit

This unit carries out one rotate or shift operation per clock for a 64-bit integer pipeline. It takes two funnel sources and a third operand. The third operand supplies either the rotate amount or the value for the bits that fall outside the mask. The unit also takes an immediate amount with a presence flag, a mode, and an optional destination window given as a start bit and a length. It registers a 64-bit result and a less/greater/equal flag triple. The result appears one clock after the inputs are presented.

Three modes are supported. The 32-bit rotate funnels the low words of the two sources and copies the rotated word into both halves of the result. The 64-bit rotate funnels the two full sources. The sign-extend-then-shift mode widens the low word of the first source to 64 bits and then shifts it left.

The window selects which result bits take the rotated value. It is counted in LSB-0 numbering and may wrap past bit 63 back to bit 0. Bits outside the window are either cleared or taken from the third operand.

Top module: `rotmask_unit`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it, `result` and all three flags are zero.
- R2: The outputs present on a clock edge reflect the inputs sampled at that same edge, so the latency is exactly one cycle.
- R3: When the window is active (`mask_en`=1, `mask_len`≠0, mode not 2), result bit i takes the rotated value exactly when (i − `mask_start`) mod 64 < `mask_len`. For example, start 31 with length 34 selects bits 31..63 and bit 0.
- R4: When `mask_en`=0 or `mask_len`=0, all 64 result bits take the rotated value.
- R5: Bits outside an active window equal `src_c` when `fill_from_c`=1 and `imm_present`=1, and are zero otherwise.
- R6: Mode 0 (32-bit) computes w = upper 32 bits of ({`src_a`[31:0], `src_b`[31:0]} << n), with n the amount's bits [4:0]. The rotated value is {w, w}.
- R7: Modes 1 and 3 (64-bit) compute the upper 64 bits of ({`src_a`, `src_b`} << n), with n the amount's bits [5:0]. With equal sources this is a left rotate.
- R8: Mode 2 sign-extends `src_a`[31:0] to 64 bits and shifts it left by the amount's bits [5:0]. The window inputs have no effect in this mode.
- R9: The amount is `imm_amt` when `imm_present`=1 and otherwise the low bits of `src_c`.
- R10: When `rec_en`=1, exactly one flag is set, from a signed comparison of the 64-bit result with zero: `flag_lt` for below zero, `flag_gt` for above zero, `flag_eq` for equal. When `rec_en`=0, all three flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 rotate32, 1 rotate64, 2 sign-extend then shift, 3 rotate64 |
| src_a | input | 64 | Upper funnel source / shift source |
| src_b | input | 64 | Lower funnel source |
| src_c | input | 64 | Register amount or outside-window fill value |
| imm_present | input | 1 | Use `imm_amt` as the amount |
| imm_amt | input | 6 | Immediate amount |
| mask_en | input | 1 | Window enable |
| mask_start | input | 6 | Lowest window bit (LSB-0) |
| mask_len | input | 6 | Window length, 0 meaning no window |
| fill_from_c | input | 1 | Outside bits come from `src_c` |
| rec_en | input | 1 | Produce the flag triple |
| result | output | 64 | Registered result |
| flag_lt | output | 1 | Result below zero |
| flag_gt | output | 1 | Result above zero |
| flag_eq | output | 1 | Result equal to zero |

## Verification
Every one of the 4096 start/length pairs is applied in 64-bit mode with random operands and random fill selection. This separates correct modulo-64 window membership, including the wrapped windows and the zero-length case, from off-by-one or non-wrapping decoders.

Random 32-bit rotates use different low words in the two sources and amounts whose bit 5 is set. This exposes a funnel that ignores the second source, uses six amount bits, or fails to duplicate the word into both halves.

Sign-extend patterns with both signs of bit 31 are run with a junk window active to show that the window has no effect. Register-amount cases with the fill flag set show that `src_c` supplies the amount and does not also fill the outside bits.

Directed results that are negative, positive and zero, each with `rec_en` high and low, tell the three flags apart from one another and from the disabled state.

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int XLEN = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic [XLEN-1:0]          src_a,
  input  logic [XLEN-1:0]          src_b,
  input  logic [XLEN-1:0]          src_c,
  input  logic                     imm_present,
  input  logic [$clog2(XLEN)-1:0]  imm_amt,
  input  logic                     mask_en,
  input  logic [$clog2(XLEN)-1:0]  mask_start,
  input  logic [$clog2(XLEN)-1:0]  mask_len,
  input  logic                     fill_from_c,
  input  logic                     rec_en,
  output logic [XLEN-1:0]          result,
  output logic                     flag_lt,
  output logic                     flag_gt,
  output logic                     flag_eq
);
  localparam int SHW  = $clog2(XLEN);
  localparam int HALF = XLEN / 2;
  localparam int HSW  = SHW - 1;

  localparam logic [1:0] M_ROT32 = 2'd0;
  localparam logic [1:0] M_SEXT  = 2'd2;

  logic [SHW-1:0]    amt;
  logic [2*XLEN-1:0] funnel_w;
  logic [XLEN-1:0]   funnel_h;
  logic [XLEN-1:0]   rot64, rot32, sext_sh, rot_v;
  logic [XLEN-1:0]   win, fill, res_n;
  logic              full;

  assign amt      = imm_present ? imm_amt : src_c[SHW-1:0];
  assign funnel_w = {src_a, src_b} << amt;
  assign rot64    = funnel_w[2*XLEN-1:XLEN];
  assign funnel_h = {src_a[HALF-1:0], src_b[HALF-1:0]} << amt[HSW-1:0];
  assign rot32    = {funnel_h[XLEN-1:HALF], funnel_h[XLEN-1:HALF]};
  assign sext_sh  = {{HALF{src_a[HALF-1]}}, src_a[HALF-1:0]} << amt;

  always_comb begin
    case (mode)
      M_ROT32: rot_v = rot32;
      M_SEXT:  rot_v = sext_sh;
      default: rot_v = rot64;
    endcase
  end

  for (genvar i = 0; i < XLEN; i++) begin : g_win
    assign win[i] = (SHW'(i) - mask_start) < mask_len;
  end

  assign full  = !mask_en || (mask_len == '0) || (mode == M_SEXT);
  assign fill  = (fill_from_c && imm_present) ? src_c : '0;
  assign res_n = full ? rot_v : ((rot_v & win) | (fill & ~win));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      flag_lt <= 1'b0;
      flag_gt <= 1'b0;
      flag_eq <= 1'b0;
    end else begin
      result  <= res_n;
      flag_lt <= rec_en && $signed(res_n) < 0;
      flag_gt <= rec_en && $signed(res_n) > 0;
      flag_eq <= rec_en && (res_n == '0);
    end
  end
endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
  parameter int XLEN = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              mode,
  input logic                    mask_en,
  input logic [$clog2(XLEN)-1:0] mask_len,
  input logic                    fill_from_c,
  input logic                    rec_en,
  input logic [XLEN-1:0]         result,
  input logic                    flag_lt,
  input logic                    flag_gt,
  input logic                    flag_eq
);
  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_lt, flag_gt, flag_eq})); // R10
  AST_FLAGS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_en |=> {flag_lt, flag_gt, flag_eq} == 3'b000); // R10
  AST_FLAG_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    rec_en |=> (flag_lt == result[XLEN-1]) && (flag_eq == (result == '0))); // R10
  AST_HALVES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !mask_en) |=> result[XLEN-1:XLEN/2] == result[XLEN/2-1:0]); // R6
  AST_SINGLE_BIT_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && mask_en && mask_len == 1 && !fill_from_c) |=> $countones(result) <= 1); // R5
endmodule

bind rotmask_unit rotmask_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/rotmask_unit_bench.sv
`timescale 1ns/1ps
module rotmask_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = '0;
  logic [63:0] src_a = '0, src_b = '0, src_c = '0;
  logic        imm_present = 1'b0;
  logic [5:0]  imm_amt = '0;
  logic        mask_en = 1'b0;
  logic [5:0]  mask_start = '0, mask_len = '0;
  logic        fill_from_c = 1'b0, rec_en = 1'b0;
  logic [63:0] result;
  logic        flag_lt, flag_gt, flag_eq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  rotmask_unit u_rotmask_unit (
    .clk(clk), .rst_n(rst_n), .mode(mode), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .imm_present(imm_present), .imm_amt(imm_amt), .mask_en(mask_en),
    .mask_start(mask_start), .mask_len(mask_len), .fill_from_c(fill_from_c),
    .rec_en(rec_en), .result(result), .flag_lt(flag_lt), .flag_gt(flag_gt), .flag_eq(flag_eq)
  );

  function automatic logic [63:0] model_res();
    int n;
    logic [31:0] w;
    logic [63:0] r, s, o;
    n = imm_present ? int'(imm_amt) : int'(src_c[5:0]);
    if (mode == 2'd0) begin
      n = n % 32;
      if (n == 0) w = src_a[31:0];
      else w = (src_a[31:0] << n) | (src_b[31:0] >> (32 - n));
      r = {w, w};
    end else if (mode == 2'd2) begin
      s = {{32{src_a[31]}}, src_a[31:0]};
      return s << n;
    end else begin
      if (n == 0) r = src_a;
      else r = (src_a << n) | (src_b >> (64 - n));
    end
    if (!mask_en || mask_len == 0) return r;
    o = r;
    for (int i = 0; i < 64; i++) begin
      if (((i - int'(mask_start) + 64) % 64) >= int'(mask_len))
        o[i] = (fill_from_c && imm_present) ? src_c[i] : 1'b0;
    end
    return o;
  endfunction

  task automatic check(string tag);
    logic [63:0] er;
    logic [2:0]  ef;
    er = model_res();
    ef = rec_en ? {$signed(er) < 0, $signed(er) > 0, er == 0} : 3'b000;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (result !== er || {flag_lt, flag_gt, flag_eq} !== ef) begin
      fails++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               tag, result, {flag_lt, flag_gt, flag_eq}, er, ef);
    end
  endtask

  task automatic set_op(logic [1:0] m, logic [63:0] a, logic [63:0] b, logic [63:0] c,
                        logic ip, logic [5:0] ia, logic me, logic [5:0] ms, logic [5:0] ml,
                        logic fc, logic re);
    mode = m; src_a = a; src_b = b; src_c = c; imm_present = ip; imm_amt = ia;
    mask_en = me; mask_start = ms; mask_len = ml; fill_from_c = fc; rec_en = re;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog: expired, expected run to finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] r;
    set_op(2'd1, '1, '1, '1, 1, 6'd3, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 0 || {flag_lt, flag_gt, flag_eq} !== 3'b000) begin
      fails++;
      $display("FAIL R1: result=%h flags=%b expected 0 000", result, {flag_lt, flag_gt, flag_eq});
    end
    rst_n = 1'b1;

    // R3 wrapped window, all-ones rotate, zero outside
    set_op(2'd1, '1, '1, '0, 1, 6'd7, 1, 6'd31, 6'd34, 0, 1);
    check("R3 wrap 31/34");
    checks++;
    if (result !== 64'hFFFF_FFFF_8000_0001) begin
      fails++;
      $display("FAIL R3: result=%h expected %h", result, 64'hFFFF_FFFF_8000_0001);
    end

    // R2 back-to-back distinct ops, R7 plain rotate
    set_op(2'd1, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, '0, 1, 6'd8, 0, 0, 0, 0, 0);
    check("R2 R7 rot 8");
    set_op(2'd3, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0001, '0, 1, 6'd63, 0, 0, 0, 0, 1);
    check("R2 R7 mode3 rot 63");

    // R3 R4 R5 full sweep
    for (int s = 0; s < 64; s++) begin
      for (int l = 0; l < 64; l++) begin
        set_op(2'd1, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
               1'b1, 6'($urandom), 1'b1, 6'(s), 6'(l), 1'($urandom), 1'($urandom));
        check(l == 0 ? "R4 len0" : (fill_from_c ? "R3 R5 fill" : "R3 R5 zero"));
      end
    end

    // R4 mask disabled
    for (int k = 0; k < 32; k++) begin
      set_op(2'd1, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
             1, 6'($urandom), 0, 6'($urandom), 6'($urandom), 1, 1);
      check("R4 mask off");
    end

    // R6 32-bit funnel
    for (int k = 0; k < 200; k++) begin
      set_op(2'd0, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
             1'($urandom), 6'($urandom), 1'($urandom), 6'($urandom), 6'($urandom),
             1'($urandom), 1'($urandom));
      check("R6 rot32");
    end
    set_op(2'd0, 64'h0, 64'h0000_0000_8000_0001, '0, 1, 6'd33, 0, 0, 0, 0, 0);
    check("R6 amt bit5 ignored");

    // R8 sign-extend then shift, window ignored
    for (int k = 0; k < 200; k++) begin
      set_op(2'd2, {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
             1'($urandom), 6'($urandom), 1, 6'($urandom), 6'($urandom), 1, 1);
      check("R8 sext");
    end
    set_op(2'd2, 64'h0000_0000_8000_0000, '0, '0, 1, 6'd4, 1, 6'd0, 6'd1, 0, 1);
    check("R8 negative ignores window");

    // R9 register amount; src_c not used as fill
    for (int k = 0; k < 200; k++) begin
      set_op(2'(($urandom % 2)), {$urandom, $urandom}, {$urandom, $urandom},
             {$urandom, $urandom}, 0, 6'($urandom), 1, 6'($urandom), 6'($urandom), 1, 1);
      check("R9 reg amount");
    end

    // R10 flag patterns
    r = 64'h0000_0000_0000_0010;
    set_op(2'd1, r, r, '0, 1, 6'd0, 0, 0, 0, 0, 1); check("R10 gt");
    set_op(2'd1, ~r, ~r, '0, 1, 6'd0, 0, 0, 0, 0, 1); check("R10 lt");
    set_op(2'd1, r, r, '0, 1, 6'd0, 1, 6'd10, 6'd3, 0, 1); check("R10 eq");
    set_op(2'd1, ~r, ~r, '0, 1, 6'd0, 0, 0, 0, 0, 0); check("R10 off");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule